// File: doc/BRIEF.md
# Multi-Window Loss Integrator with Energy-Indexed Trip

This block receives one loss-count sample per detector channel on every sample strobe and keeps, per channel, twelve integration windows of increasing length. The shortest window is the newest sample on its own. Three more are running sums over the most recent raw samples. Four longer windows run over block sums of eight samples. The four longest run over averaged data, where each value is the mean of four block sums. This keeps the delay lines short while the covered time span grows by about two orders of magnitude.

Each window is compared every cycle against a threshold taken from an internal table. The table is indexed by channel, by the current beam-energy word (32 levels) and by window index. A host loads the table through a write port that only takes effect while a permit input is high. The first exceedance latches a dump request together with the channel and window that caused it. The record holds until the host pulses a clear input.

Top module: `loss_window_guard`

## Requirements
- R1: Windows 0 to 3 of a channel are sums of that channel's latest 1, 2, 4 and 8 accepted samples; a sample is accepted on every cycle with `sample_vld` high, channel c taking bits `[c*SW +: SW]` of `loss_in`.
- R2: Every eighth accepted sample closes a block whose value is the sum of those eight samples; windows 4 to 7 are sums of the latest 2, 4, 8 and 16 blocks.
- R3: Every fourth block produces an average equal to the sum of those four block values divided by four; windows 8 to 11 are sums of the latest 2, 4, 6 and 8 averages.
- R4: A window cannot trip until it holds its full count of samples, blocks or averages; partial sums after reset are ignored.
- R5: A window exceeds when its sum is strictly greater than the table entry selected by its channel, the present `beam_energy` and its window index; equality does not trip.
- R6: A table write at `thr_addr` = {channel, energy[4:0], window[3:0]} (window in bits 3:0, energy in bits 8:4, channel above) stores `thr_data` only when `thr_we` and `thr_permit` are both high and the window code is below 12; after reset every entry holds all ones.
- R7: The first exceedance sets `dump_req` and records `trip_chan` and `trip_win`; these stay unchanged while further exceedances occur, until `dump_clr`.
- R8: When several windows exceed in the same cycle, the lowest channel wins, then the lowest window index.
- R9: `dump_clr` drops `dump_req` on the following edge; if an exceedance persists, the request latches again one edge later.
- R10: After reset `dump_req`, `trip_chan` and `trip_win` are zero and all sums are empty.
- R11: No sum wraps: full-scale input on every sample still gives the exact window value in the longest block window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_vld | input | 1 | Strobe: one new sample per channel |
| loss_in | input | NCH*SW | Packed loss samples, channel 0 in the low bits |
| beam_energy | input | 5 | Energy level selecting the threshold row |
| thr_we | input | 1 | Table write strobe |
| thr_permit | input | 1 | Table write permit |
| thr_addr | input | CHW+9 | Table address {channel, energy, window} |
| thr_data | input | TW | Threshold value to store |
| dump_clr | input | 1 | Clears the latched dump request |
| dump_req | output | 1 | Latched dump request |
| trip_chan | output | CHW | Channel of the first exceedance |
| trip_win | output | 4 | Window index of the first exceedance |

## Verification
The first edge at which `dump_req` can be high is fixed by the register path. A raw window of T samples latches one edge after its T-th sample. A block window of T blocks latches two edges after sample 8T, and an averaged window of T averages latches three edges after sample 32T. A change of `beam_energy` or a new table entry reaches the latch on the next edge. Each scenario counts edges from the first strobe and samples one nanosecond after an edge. It checks that the request is still low one edge before the due edge and high with the right channel and window on it, so a one-cycle slip or an early partial-window trip is reported.

// File: rtl/lwg_pkg.sv
package lwg_pkg;
  localparam int NWIN       = 12;
  localparam int WINW       = 4;
  localparam int EW         = 5;
  localparam int NE         = 1 << EW;
  localparam int DEC1       = 8;
  localparam int DEC2       = 4;
  localparam int AVG_SHIFT  = 2;
  localparam int R1_DEPTH   = 8;
  localparam int R2_DEPTH   = 16;
  localparam int R3_DEPTH   = 8;
  localparam int R1_TAPS [4] = '{1, 2, 4, 8};
  localparam int R2_TAPS [4] = '{2, 4, 8, 16};
  localparam int R3_TAPS [4] = '{2, 4, 6, 8};
endpackage

// File: rtl/lwg_block_accum.sv
module lwg_block_accum #(
  parameter int IW    = 10,
  parameter int DEC   = 8,
  parameter int SHIFT = 0,
  parameter int OW    = IW + $clog2(DEC) - SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [IW-1:0] in_val,
  output logic          out_vld,
  output logic [OW-1:0] out_val
);
  localparam int AW = IW + $clog2(DEC);
  localparam int CW = $clog2(DEC);

  logic [AW-1:0] acc_q, acc_d, tot;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [OW-1:0] val_q, val_d;
  logic          vld_q, vld_d, wrap;

  always_comb begin
    wrap  = (cnt_q == CW'(DEC - 1));
    tot   = acc_q + AW'(in_val);
    acc_d = wrap ? '0 : tot;
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    val_d = OW'(tot >> SHIFT);
    vld_d = in_vld && wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
      val_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (in_vld) begin
        acc_q <= acc_d;
        cnt_q <= cnt_d;
        if (wrap) val_q <= val_d;
      end
    end
  end

  assign out_vld = vld_q;
  assign out_val = val_q;

  // R2/R3: a block closes at most once per DEC accepted inputs
  assert_block_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld);
endmodule

// File: rtl/lwg_rs_region.sv
module lwg_rs_region #(
  parameter int IW       = 10,
  parameter int DEPTH    = 8,
  parameter int TAPS [4] = '{1, 2, 4, 8},
  parameter int OW       = IW + $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic [IW-1:0]       in_val,
  output logic [3:0][OW-1:0]  sum_o,
  output logic [3:0]          rdy_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][IW-1:0] line_q, line_d;
  logic [CW-1:0]            cnt_q, cnt_d;
  logic [3:0][OW-1:0]       sum_q, sum_d;

  always_comb begin
    line_d[0] = in_val;
    for (int i = 1; i < DEPTH; i++) line_d[i] = line_q[i-1];
    cnt_d = (cnt_q == CW'(DEPTH)) ? cnt_q : cnt_q + 1'b1;
    for (int k = 0; k < 4; k++) begin
      sum_d[k] = sum_q[k] + OW'(in_val)
               - ((cnt_q >= CW'(TAPS[k])) ? OW'(line_q[TAPS[k]-1]) : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      cnt_q  <= '0;
      sum_q  <= '0;
    end else if (in_vld) begin
      line_q <= line_d;
      cnt_q  <= cnt_d;
      sum_q  <= sum_d;
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_tap
    assign rdy_o[k] = (cnt_q >= CW'(TAPS[k]));
    assign sum_o[k] = sum_q[k];

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sum_q[k] <= OW'(TAPS[k] * ((1 << IW) - 1)));
  end
endmodule

// File: rtl/lwg_thr_table.sv
module lwg_thr_table #(
  parameter int NCH  = 2,
  parameter int NWIN = 12,
  parameter int NE   = 32,
  parameter int TW   = 17,
  parameter int CHW  = 1,
  parameter int EW   = $clog2(NE),
  parameter int WW   = $clog2(NWIN),
  parameter int AW   = CHW + EW + WW
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic                                permit,
  input  logic [AW-1:0]                       wr_addr,
  input  logic [TW-1:0]                       wr_data,
  input  logic [EW-1:0]                       energy,
  output logic [NCH-1:0][NWIN-1:0][TW-1:0]    thr_o
);
  localparam int NENT = NCH * NE * NWIN;

  logic [NENT-1:0][TW-1:0] mem_q, mem_d;
  logic [WW-1:0]           a_win;
  logic [EW-1:0]           a_en;
  logic [CHW-1:0]          a_ch;
  logic                    hit;
  int                      idx;

  always_comb begin
    a_win = wr_addr[WW-1:0];
    a_en  = wr_addr[WW+EW-1:WW];
    a_ch  = wr_addr[AW-1:WW+EW];
    hit   = wr_en && permit && (int'(a_win) < NWIN) && (int'(a_ch) < NCH);
    idx   = int'(a_ch) * NE * NWIN + int'(a_en) * NWIN + int'(a_win);
    mem_d = mem_q;
    if (hit) mem_d[idx] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mem_q <= '1;
    else if (hit) mem_q <= mem_d;
  end

  always_comb begin
    for (int c = 0; c < NCH; c++)
      for (int w = 0; w < NWIN; w++)
        thr_o[c][w] = mem_q[c * NE * NWIN + int'(energy) * NWIN + w];
  end

  assert_permit_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !permit |=> $stable(mem_q));
endmodule

// File: rtl/loss_window_guard.sv
module loss_window_guard
  import lwg_pkg::*;
#(
  parameter  int NCH = 2,
  parameter  int SW  = 10,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int R1W = SW + $clog2(R1_DEPTH),
  localparam int B1W = SW + $clog2(DEC1),
  localparam int R2W = B1W + $clog2(R2_DEPTH),
  localparam int B2W = B1W + $clog2(DEC2) - AVG_SHIFT,
  localparam int R3W = B2W + $clog2(R3_DEPTH),
  localparam int TW  = R2W,
  localparam int TAW = CHW + EW + WINW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_vld,
  input  logic [NCH*SW-1:0] loss_in,
  input  logic [EW-1:0]     beam_energy,
  input  logic              thr_we,
  input  logic              thr_permit,
  input  logic [TAW-1:0]    thr_addr,
  input  logic [TW-1:0]     thr_data,
  input  logic              dump_clr,
  output logic              dump_req,
  output logic [CHW-1:0]    trip_chan,
  output logic [WINW-1:0]   trip_win
);
  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [NCH-1:0][NWIN-1:0][TW-1:0] win_sum;
  logic [NCH-1:0][NWIN-1:0][TW-1:0] win_thr;
  logic [NCH-1:0][NWIN-1:0]         win_rdy;
  logic [NCH-1:0][NWIN-1:0]         exc;

  lwg_thr_table #(
    .NCH(NCH), .NWIN(NWIN), .NE(NE), .TW(TW), .CHW(CHW), .EW(EW), .WW(WINW), .AW(TAW)
  ) u_table (
    .clk(clk), .rst_n(rst_sync), .wr_en(thr_we), .permit(thr_permit),
    .wr_addr(thr_addr), .wr_data(thr_data), .energy(beam_energy), .thr_o(win_thr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [3:0][R1W-1:0] r1_sum;
    logic [3:0][R2W-1:0] r2_sum;
    logic [3:0][R3W-1:0] r3_sum;
    logic [3:0]          r1_rdy, r2_rdy, r3_rdy;
    logic                b1_vld, b2_vld;
    logic [B1W-1:0]      b1_val;
    logic [B2W-1:0]      b2_val;

    lwg_rs_region #(.IW(SW), .DEPTH(R1_DEPTH), .TAPS(R1_TAPS), .OW(R1W)) u_r1 (
      .clk(clk), .rst_n(rst_sync), .in_vld(sample_vld),
      .in_val(loss_in[c*SW +: SW]), .sum_o(r1_sum), .rdy_o(r1_rdy));

    lwg_block_accum #(.IW(SW), .DEC(DEC1), .SHIFT(0), .OW(B1W)) u_b1 (
      .clk(clk), .rst_n(rst_sync), .in_vld(sample_vld),
      .in_val(loss_in[c*SW +: SW]), .out_vld(b1_vld), .out_val(b1_val));

    lwg_rs_region #(.IW(B1W), .DEPTH(R2_DEPTH), .TAPS(R2_TAPS), .OW(R2W)) u_r2 (
      .clk(clk), .rst_n(rst_sync), .in_vld(b1_vld),
      .in_val(b1_val), .sum_o(r2_sum), .rdy_o(r2_rdy));

    lwg_block_accum #(.IW(B1W), .DEC(DEC2), .SHIFT(AVG_SHIFT), .OW(B2W)) u_b2 (
      .clk(clk), .rst_n(rst_sync), .in_vld(b1_vld),
      .in_val(b1_val), .out_vld(b2_vld), .out_val(b2_val));

    lwg_rs_region #(.IW(B2W), .DEPTH(R3_DEPTH), .TAPS(R3_TAPS), .OW(R3W)) u_r3 (
      .clk(clk), .rst_n(rst_sync), .in_vld(b2_vld),
      .in_val(b2_val), .sum_o(r3_sum), .rdy_o(r3_rdy));

    for (genvar k = 0; k < 4; k++) begin : g_k
      assign win_sum[c][k]   = TW'(r1_sum[k]);
      assign win_sum[c][k+4] = TW'(r2_sum[k]);
      assign win_sum[c][k+8] = TW'(r3_sum[k]);
      assign win_rdy[c][k]   = r1_rdy[k];
      assign win_rdy[c][k+4] = r2_rdy[k];
      assign win_rdy[c][k+8] = r3_rdy[k];
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_cmp
      assign exc[c][w] = win_rdy[c][w] && (win_sum[c][w] > win_thr[c][w]);
    end
  end

  logic            any_exc;
  logic [CHW-1:0]  sel_ch;
  logic [WINW-1:0] sel_win;

  always_comb begin
    any_exc = 1'b0;
    sel_ch  = '0;
    sel_win = '0;
    for (int c = 0; c < NCH; c++) begin
      for (int w = 0; w < NWIN; w++) begin
        if (!any_exc && exc[c][w]) begin
          any_exc = 1'b1;
          sel_ch  = CHW'(c);
          sel_win = WINW'(w);
        end
      end
    end
  end

  logic            req_q, req_d;
  logic [CHW-1:0]  ch_q, ch_d;
  logic [WINW-1:0] win_q, win_d;
  logic            rec_en;

  always_comb begin
    rec_en = !dump_clr && !req_q && any_exc;
    req_d  = dump_clr ? 1'b0 : (req_q || any_exc);
    ch_d   = dump_clr ? '0 : sel_ch;
    win_d  = dump_clr ? '0 : sel_win;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      req_q <= 1'b0;
      ch_q  <= '0;
      win_q <= '0;
    end else begin
      req_q <= req_d;
      if (rec_en || dump_clr) begin
        ch_q  <= ch_d;
        win_q <= win_d;
      end
    end
  end

  assign dump_req  = req_q;
  assign trip_chan = ch_q;
  assign trip_win  = win_q;

  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync)
    (req_q && !dump_clr) |=> (req_q && $stable(ch_q) && $stable(win_q)));

  assert_win_range_R7: assert property (@(posedge clk) disable iff (!rst_sync)
    req_q |-> (int'(win_q) < NWIN));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_sync)
    dump_clr |=> !req_q);

  assert_cause_R5: assert property (@(posedge clk) disable iff (!rst_sync)
    $rose(req_q) |-> $past(any_exc));
endmodule

// File: tb/loss_window_guard_test.sv
module loss_window_guard_test;
  localparam int NCH  = 2;
  localparam int SW   = 10;
  localparam int TW   = 17;
  localparam int MAXV = (1 << SW) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              sample_vld;
  logic [NCH*SW-1:0] loss_in;
  logic [4:0]        beam_energy;
  logic              thr_we, thr_permit;
  logic [9:0]        thr_addr;
  logic [TW-1:0]     thr_data;
  logic              dump_clr;
  logic              dump_req;
  logic [0:0]        trip_chan;
  logic [3:0]        trip_win;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  always #2 clk = ~clk;

  loss_window_guard #(.NCH(NCH), .SW(SW)) uut (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .loss_in(loss_in),
    .beam_energy(beam_energy), .thr_we(thr_we), .thr_permit(thr_permit),
    .thr_addr(thr_addr), .thr_data(thr_data), .dump_clr(dump_clr),
    .dump_req(dump_req), .trip_chan(trip_chan), .trip_win(trip_win));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sample_vld = 1'b0; loss_in = '0; beam_energy = 5'd3;
    thr_we = 1'b0; thr_permit = 1'b0; thr_addr = '0; thr_data = '0; dump_clr = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic wr_thr(input int ch, input int en, input int win, input int val, input bit perm);
    thr_addr   = {ch[0:0], en[4:0], win[3:0]};
    thr_data   = TW'(val);
    thr_permit = perm;
    thr_we     = 1'b1;
    tick();
    thr_we     = 1'b0;
    thr_permit = 1'b0;
  endtask

  // Drive a constant value on one channel; the trip must appear exactly at edge x.
  task automatic trip_scenario(input string tag, input int ch, input int win,
                               input int v, input int thr, input int x);
    do_reset();
    wr_thr(ch, 3, win, thr, 1'b1);
    loss_in = '0;
    loss_in[ch*SW +: SW] = SW'(v);
    sample_vld = 1'b1;
    for (int n = 1; n <= x; n++) begin
      tick();
      if (n == x - 1) check({"R4 early trip before ", tag}, int'(dump_req), 0);
      if (n == x) begin
        check({tag, " dump_req"}, int'(dump_req), 1);
        check({tag, " trip_win"}, int'(trip_win), win);
        check({tag, " trip_chan"}, int'(trip_chan), ch);
      end
    end
    sample_vld = 1'b0;
  endtask

  task automatic test_reset();
    do_reset();
    check("R10 dump_req", int'(dump_req), 0);
    check("R10 trip_chan", int'(trip_chan), 0);
    check("R10 trip_win", int'(trip_win), 0);
  endtask

  task automatic test_energy();
    do_reset();
    wr_thr(0, 3, 0, 4, 1'b1);
    wr_thr(0, 9, 0, 3, 1'b1);
    beam_energy = 5'd3;
    loss_in = '0; loss_in[SW-1:0] = SW'(4);
    sample_vld = 1'b1;
    repeat (5) tick();
    check("R5 equal sum no trip", int'(dump_req), 0);
    beam_energy = 5'd9;
    tick();
    check("R5 energy row trip", int'(dump_req), 1);
    check("R5 energy row win", int'(trip_win), 0);
    sample_vld = 1'b0;
  endtask

  task automatic test_permit();
    do_reset();
    beam_energy = 5'd4;
    wr_thr(0, 4, 0, 0, 1'b0);
    wr_thr(0, 3, 12, 0, 1'b1);
    loss_in = '0; loss_in[SW-1:0] = SW'(4);
    sample_vld = 1'b1;
    repeat (10) tick();
    check("R6 blocked writes", int'(dump_req), 0);
    wr_thr(0, 4, 0, 0, 1'b1);
    tick();
    check("R6 permitted write", int'(dump_req), 1);
    sample_vld = 1'b0;
  endtask

  task automatic test_latch();
    do_reset();
    wr_thr(0, 3, 0, 0, 1'b1);
    wr_thr(1, 3, 0, 0, 1'b1);
    wr_thr(0, 3, 3, 0, 1'b1);
    loss_in = {SW'(5), SW'(5)};
    sample_vld = 1'b1;
    for (int n = 1; n <= 10; n++) begin
      tick();
      if (n == 2) begin
        check("R8 chan tie", int'(trip_chan), 0);
        check("R8 win tie", int'(trip_win), 0);
      end
      if (n == 10) begin
        check("R7 held req", int'(dump_req), 1);
        check("R7 held chan", int'(trip_chan), 0);
        check("R7 held win", int'(trip_win), 0);
      end
    end
    sample_vld = 1'b0;
    dump_clr = 1'b1;
    tick();
    dump_clr = 1'b0;
    check("R9 cleared", int'(dump_req), 0);
    tick();
    check("R9 relatched", int'(dump_req), 1);
    check("R9 relatched win", int'(trip_win), 0);
    wr_thr(0, 3, 0, (1 << TW) - 1, 1'b1);
    wr_thr(0, 3, 3, (1 << TW) - 1, 1'b1);
    dump_clr = 1'b1;
    tick();
    dump_clr = 1'b0;
    check("R9 cleared again", int'(dump_req), 0);
    tick();
    check("R8 next source chan", int'(trip_chan), 1);
    check("R8 next source win", int'(trip_win), 0);
  endtask

  initial begin
    test_reset();
    trip_scenario("R1 raw window", 0, 0, 7, 6, 2);
    trip_scenario("R1 eight-sample window", 1, 3, 5, 0, 9);
    trip_scenario("R2 two-block window", 0, 4, 3, 47, 18);
    trip_scenario("R11 full-scale sixteen blocks", 1, 7, MAXV, 16 * 8 * MAXV - 1, 130);
    trip_scenario("R3 two-average window", 0, 8, 6, 95, 67);
    trip_scenario("R3 eight-average window", 1, 11, 2, 127, 259);
    test_energy();
    test_permit();
    test_latch();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule